// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask

This block turns the status flags of a serial port into an interrupt status byte and one interrupt request line. The transmit bit copies the transmitter-ready flag. The receive bit follows one of two receiver flags, and a mode bit chooses which one. A delta-break bit is set when a break is seen and stays set until a clear command removes it. The change-of-state bit is reserved and always reads zero.

Software writes a mask byte. The interrupt request is high while any status bit is set together with its mask bit. The status byte and the request are both registered and take their new values on the clock edge that follows an input change. Another block generates the status flags; this block only reads them.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is high and on the first edge after it, the status byte is 0x00 and the request is low. Reset also sets the mask to 0x00.
- R2: Status bit 0 (transmit) equals the transmitter-ready input as sampled on the previous clock edge.
- R3: When the receive-select mode bit is 0, status bit 1 (receive) equals the receiver-ready input as sampled on the previous edge, and the FIFO-full input has no effect on it.
- R4: When the receive-select mode bit is 1, status bit 1 equals the FIFO-full input as sampled on the previous edge, and the receiver-ready input has no effect on it.
- R5: A break strobe sets status bit 2 (delta-break) on the next edge. The bit then holds with no further strobes.
- R6: A clear-break strobe with no break strobe in the same cycle clears status bit 2 on the next edge.
- R7: When a break strobe and a clear-break strobe arrive in the same cycle, status bit 2 is 1 after the edge.
- R8: The request equals the OR of (status byte AND mask). It takes its new value on the same edge as the status byte and on the edge that stores a new mask.
- R9: Status bits 3 to 7 always read 0. Bit 7 is the reserved change-of-state bit.
- R10: The mask is replaced by the write data only on an edge where the mask write enable is high. With the enable low, the write data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_tx_ready | input | 1 | Transmitter-ready status flag |
| flag_rx_ready | input | 1 | Receiver-ready status flag |
| flag_fifo_full | input | 1 | Receive FIFO-full status flag |
| rx_src_full | input | 1 | Mode bit: 1 selects FIFO-full as the receive interrupt source |
| break_seen | input | 1 | One-cycle strobe: a break was detected |
| break_clear | input | 1 | One-cycle strobe: clear-break command |
| mask_wr | input | 1 | Mask write enable |
| mask_wdata | input | 8 | Mask write data |
| irq_status | output | 8 | Interrupt status byte |
| irq_out | output | 1 | Level interrupt request |

## Verification
Every result of this block is due exactly one clock edge after its cause. This holds for a flag change, a mode change, a break or clear strobe, and a mask write. The bench drives inputs on the falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. A second read after further idle edges confirms that the delta-break bit holds and that inputs which should be ignored have changed nothing.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STAT_W  = 8;
  localparam int TX_POS  = 0;
  localparam int RX_POS  = 1;
  localparam int BRK_POS = 2;
  localparam int COS_POS = 7;
endpackage

// File: rtl/uirq_src_sel.sv
module uirq_src_sel (
  input  logic use_full,
  input  logic tx_ready,
  input  logic rx_ready,
  input  logic fifo_full,
  output logic tx_bit,
  output logic rx_bit
);
  always_comb begin
    tx_bit = tx_ready;
    rx_bit = use_full ? fifo_full : rx_ready;
  end
endmodule

// File: rtl/uirq_brk_hold.sv
module uirq_brk_hold (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_next,
  output logic flag_q
);
  // set has priority over clear
  always_comb begin
    if (set_i)      flag_next = 1'b1;
    else if (clr_i) flag_next = 1'b0;
    else            flag_next = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_next;
  end
endmodule

// File: rtl/uirq_mask_gen.sv
module uirq_mask_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] stat_next,
  output logic [W-1:0] mask_q,
  output logic         req_q
);
  logic [W-1:0] mask_next;

  always_comb mask_next = wr_en ? wr_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      req_q  <= 1'b0;
    end else begin
      mask_q <= mask_next;
      req_q  <= |(stat_next & mask_next);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flag_tx_ready,
  input  logic         flag_rx_ready,
  input  logic         flag_fifo_full,
  input  logic         rx_src_full,
  input  logic         break_seen,
  input  logic         break_clear,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] irq_status,
  output logic         irq_out
);
  logic         tx_bit, rx_bit;
  logic         brk_next, brk_q;
  logic [W-1:0] stat_next, stat_q;
  logic [W-1:0] mask_q;

  uirq_src_sel u_sel (
    .use_full (rx_src_full),
    .tx_ready (flag_tx_ready),
    .rx_ready (flag_rx_ready),
    .fifo_full(flag_fifo_full),
    .tx_bit   (tx_bit),
    .rx_bit   (rx_bit)
  );

  uirq_brk_hold u_brk (
    .clk      (clk),
    .rst      (rst),
    .set_i    (break_seen),
    .clr_i    (break_clear),
    .flag_next(brk_next),
    .flag_q   (brk_q)
  );

  // next status byte; reserved positions, including change-of-state, stay 0
  always_comb begin
    stat_next          = '0;
    stat_next[TX_POS]  = tx_bit;
    stat_next[RX_POS]  = rx_bit;
    stat_next[BRK_POS] = brk_next;
    stat_next[COS_POS] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= {stat_next[W-1:BRK_POS+1], 1'b0, stat_next[RX_POS:0]};
  end

  uirq_mask_gen #(.W(W)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mask_wr),
    .wr_data  (mask_wdata),
    .stat_next(stat_next),
    .mask_q   (mask_q),
    .req_q    (irq_out)
  );

  assign irq_status = {stat_q[W-1:BRK_POS+1], brk_q, stat_q[RX_POS:0]};
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         flag_tx_ready,
  input logic         flag_rx_ready,
  input logic         flag_fifo_full,
  input logic         rx_src_full,
  input logic         break_seen,
  input logic         break_clear,
  input logic [W-1:0] irq_status,
  input logic [W-1:0] mask_q,
  input logic         irq_out
);
  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    seen_edge && $past(rst) |-> (irq_status == '0) && !irq_out);

  assert_tx_follow_R2: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) |-> irq_status[0] == $past(flag_tx_ready));

  assert_rx_ready_R3: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && !$past(rx_src_full) |-> irq_status[1] == $past(flag_rx_ready));

  assert_rx_full_R4: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && $past(rx_src_full) |-> irq_status[1] == $past(flag_fifo_full));

  assert_brk_set_R5: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && $past(break_seen) |-> irq_status[2]);

  assert_brk_hold_R5: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && !$past(break_seen) && !$past(break_clear)
    |-> irq_status[2] == $past(irq_status[2]));

  assert_brk_clr_R6: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && $past(break_clear) && !$past(break_seen) |-> !irq_status[2]);

  assert_brk_both_R7: assert property (@(posedge clk) disable iff (rst)
    seen_edge && !$past(rst) && $past(break_clear) && $past(break_seen) |-> irq_status[2]);

  assert_req_mask_R8: assert property (@(posedge clk) disable iff (rst)
    seen_edge |-> irq_out == |(irq_status & mask_q));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    seen_edge |-> irq_status[W-1:3] == '0);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .flag_tx_ready (flag_tx_ready),
  .flag_rx_ready (flag_rx_ready),
  .flag_fifo_full(flag_fifo_full),
  .rx_src_full   (rx_src_full),
  .break_seen    (break_seen),
  .break_clear   (break_clear),
  .irq_status    (irq_status),
  .mask_q        (mask_q),
  .irq_out       (irq_out)
);

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_r = 0, rx_r = 0, full_r = 0, sel_r = 0;
  logic       brk_s = 0, brk_c = 0, mwr = 0;
  logic [7:0] mdat = 8'h00;
  logic [7:0] stat;
  logic       irq;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst(rst),
    .flag_tx_ready(tx_r), .flag_rx_ready(rx_r), .flag_fifo_full(full_r),
    .rx_src_full(sel_r), .break_seen(brk_s), .break_clear(brk_c),
    .mask_wr(mwr), .mask_wdata(mdat),
    .irq_status(stat), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wmask(input logic [7:0] v);
    mwr = 1; mdat = v; tick(); mwr = 0;
  endtask

  task automatic t_reset;
    tx_r = 1; rx_r = 1; brk_s = 1;
    rst = 1; tick(2);
    chk("R1 status in reset", stat, 8'h00);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    brk_s = 0; tx_r = 0; rx_r = 0;
    rst = 0; tick();
    chk("R1 status after reset", stat, 8'h00);
  endtask

  task automatic t_tx;
    tx_r = 1; tick();
    chk("R2 tx set", stat, 8'h01);
    chk("R1 mask zero after reset", {7'b0, irq}, 8'h00);
    wmask(8'h01);
    chk("R8 irq with tx mask", {7'b0, irq}, 8'h01);
    mdat = 8'h00; tick(2);
    chk("R10 data ignored without enable", {7'b0, irq}, 8'h01);
    tx_r = 0; tick();
    chk("R2 tx clear", stat, 8'h00);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rx_ready;
    sel_r = 0; wmask(8'h02);
    rx_r = 1; full_r = 0; tick();
    chk("R3 rx ready selected", stat, 8'h02);
    chk("R8 rx irq", {7'b0, irq}, 8'h01);
    rx_r = 0; full_r = 1; tick();
    chk("R3 full ignored", stat, 8'h00);
    chk("R3 irq low", {7'b0, irq}, 8'h00);
    full_r = 0;
  endtask

  task automatic t_rx_full;
    sel_r = 1; rx_r = 1; full_r = 0; tick();
    chk("R4 ready ignored", stat, 8'h00);
    rx_r = 0; full_r = 1; tick();
    chk("R4 full selected", stat, 8'h02);
    chk("R8 full irq", {7'b0, irq}, 8'h01);
    full_r = 0; sel_r = 0;
  endtask

  task automatic t_break;
    wmask(8'h04);
    brk_s = 1; tick(); brk_s = 0;
    chk("R5 break sets", stat, 8'h04);
    chk("R8 break irq", {7'b0, irq}, 8'h01);
    tick(5);
    chk("R5 break holds", stat, 8'h04);
    brk_c = 1; tick(); brk_c = 0;
    chk("R6 clear", stat, 8'h00);
    chk("R6 irq drops", {7'b0, irq}, 8'h00);
    brk_s = 1; brk_c = 1; tick(); brk_s = 0; brk_c = 0;
    chk("R7 break wins", stat, 8'h04);
    brk_s = 1; brk_c = 1; tick(); brk_s = 0; brk_c = 0;
    chk("R7 break wins when set", stat, 8'h04);
    brk_c = 1; tick(); brk_c = 0;
    chk("R6 clear again", stat, 8'h00);
  endtask

  task automatic t_reserved;
    wmask(8'hFF);
    tx_r = 1; rx_r = 1; brk_s = 1; tick(); brk_s = 0;
    chk("R9 upper bits zero", stat, 8'h07);
    wmask(8'hF8);
    chk("R9 irq from reserved bits", {7'b0, irq}, 8'h00);
    wmask(8'h00);
    chk("R10 mask zero write", {7'b0, irq}, 8'h00);
    wmask(8'h02);
    chk("R10 new mask applied", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_reset_mask;
    rst = 1; tick(); rst = 0; tick();
    chk("R1 status cleared", stat, 8'h03);
    chk("R1 mask cleared", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset();
    t_tx();
    t_rx_ready();
    t_rx_full();
    t_break();
    t_reserved();
    t_reset_mask();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule